// File: doc/BRIEF.md
# Configurable pin interrupt detector

This block watches a group of already-synchronised input pins and turns selected activity on them into one interrupt request. Each pin has its own trigger kind: rising edge, falling edge, either edge, high level or low level. Edge events are held in a per-pin pending flag until software writes a one to that pin's clear input. Level pins report their condition live, so the pending flag tracks the pin each cycle. A per-pin enable decides which pending flags reach the shared request line.

The trigger kind is held in a type word of three bit planes, each `NUM_PINS` bits wide. The word is decoded in place, so no separate mode register is needed. For pin n, plane 0 holds the polarity, plane 1 selects edge operation and plane 2 selects edge detection on both transitions. The block has no register decode of its own. It sits behind a port-level register file that supplies the type, enable and clear vectors.

Top module: `pin_irq_detect`

## Requirements
- R1: While `rst` is high at a clock edge, `status` and `irq` are all zero at the end of that cycle.
- R2: With type bits {plane2,plane1,plane0} = {0,1,1} at positions 2N+n, N+n and n, a 0-to-1 transition of pin n sets status bit n one clock after it is sampled. A 1-to-0 transition does not set it.
- R3: With type bits {0,1,0} for pin n, a 1-to-0 transition sets status bit n. A 0-to-1 transition does not set it.
- R4: With plane 1 and plane 2 both set for pin n, either transition sets status bit n, whatever plane 0 holds.
- R5: With plane 1 clear and plane 0 set, status bit n equals the pin value sampled at the previous clock edge. Plane 2 is ignored.
- R6: With plane 1 clear and plane 0 clear, status bit n equals the inverse of the pin value sampled at the previous clock edge.
- R7: In an edge mode, a set status bit stays set until a cycle in which clear bit n is 1. That cycle clears it. A clear bit of 0 has no effect.
- R8: In an edge mode, if a clear and a new qualifying edge on pin n fall in the same cycle, status bit n stays set.
- R9: In a level mode, a clear on pin n has no effect on status bit n. The status keeps following the level.
- R10: `irq` is 1 in the cycle after one in which any status bit is 1 together with its enable bit. Otherwise it is 0. Status bits are set regardless of their enable.
- R11: The first clock edge after reset only records the pin values. No edge is detected at that edge, whatever the pins held during reset.
- R12: Every pin decodes its own three plane bits independently, so all five trigger kinds can be active on different pins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | NUM_PINS | Synchronised pin samples |
| trig_type | input | 3*NUM_PINS | Trigger planes: polarity, edge select, dual edge |
| irq_en | input | NUM_PINS | Per-pin interrupt enable |
| irq_clr | input | NUM_PINS | Write-one-to-clear pulses for pending status |
| status | output | NUM_PINS | Pending status per pin |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The hardest situation to reach is a clear that coincides with a fresh edge on the same pin. The pin must be toggled and the clear must be asserted in the very same cycle, after an earlier edge has already set the bit. The stimulus steps pins one cycle at a time and schedules such overlaps on purpose. It also changes pins while reset is held, then releases reset with different values, to exercise the first-edge priming. A long pseudo-random phase then varies pins, clears, enables and per-pin trigger kinds together. A reference model written from the requirements predicts every cycle.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    typedef enum logic [2:0] {
        TRIG_LVL_LOW  = 3'd0,
        TRIG_LVL_HIGH = 3'd1,
        TRIG_RISE     = 3'd2,
        TRIG_FALL     = 3'd3,
        TRIG_BOTH     = 3'd4
    } trig_e;

    // One pin's slice of the three planes
    typedef struct packed {
        logic dual;
        logic edge_sel;
        logic pol;
    } trig_bits_t;

    function automatic trig_e decode_trig(input trig_bits_t b);
        trig_e m;
        if (!b.edge_sel)
            m = b.pol ? TRIG_LVL_HIGH : TRIG_LVL_LOW;
        else if (b.dual)
            m = TRIG_BOTH;
        else
            m = b.pol ? TRIG_RISE : TRIG_FALL;
        return m;
    endfunction

    function automatic logic is_edge_mode(input trig_e m);
        return (m == TRIG_RISE) || (m == TRIG_FALL) || (m == TRIG_BOTH);
    endfunction

endpackage

// File: rtl/pin_trig_decode.sv
module pin_trig_decode
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic [3*NUM_PINS-1:0] type_i,
    output trig_e                 mode_o [NUM_PINS]
);
    localparam int PLANE = NUM_PINS;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_dec
        trig_bits_t bits;
        assign bits.pol      = type_i[g];
        assign bits.edge_sel = type_i[PLANE + g];
        assign bits.dual     = type_i[2*PLANE + g];
        assign mode_o[g]     = decode_trig(bits);
    end
endmodule

// File: rtl/pin_edge_detect.sv
module pin_edge_detect #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] fall_o
);
    logic [NUM_PINS-1:0] prev_q;
    logic                primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= pin_i;
            primed_q <= 1'b1;
        end
    end

    assign rise_o = {NUM_PINS{primed_q}} &  pin_i & ~prev_q;
    assign fall_o = {NUM_PINS{primed_q}} & ~pin_i &  prev_q;

    // R11: no transition reported on the first edge out of reset
    p_unprimed_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rise_o == '0 && fall_o == '0));
endmodule

// File: rtl/pin_status_cell.sv
module pin_status_cell
    import pin_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  trig_e mode_i,
    input  logic  pin_i,
    input  logic  rise_i,
    input  logic  fall_i,
    input  logic  clr_i,
    output logic  status_o
);
    logic hit;
    logic edge_m;
    logic lvl_on;
    logic status_d;

    always_comb begin
        unique case (mode_i)
            TRIG_RISE: hit = rise_i;
            TRIG_FALL: hit = fall_i;
            TRIG_BOTH: hit = rise_i | fall_i;
            default:   hit = 1'b0;
        endcase
        edge_m   = is_edge_mode(mode_i);
        lvl_on   = (mode_i == TRIG_LVL_HIGH) ? pin_i : ~pin_i;
        status_d = edge_m ? (hit | (status_o & ~clr_i)) : lvl_on;
    end

    always_ff @(posedge clk) begin
        if (rst) status_o <= 1'b0;
        else     status_o <= status_d;
    end

    // R7: pending edge status holds without a clear
    p_edge_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (edge_m && status_o && !clr_i) |=> status_o);

    // R8: new edge wins over a simultaneous clear
    p_edge_beats_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (edge_m && hit && clr_i) |=> status_o);

    // R9: level modes track the pin regardless of clear
    p_level_track_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_i == TRIG_LVL_HIGH) |=> (status_o == $past(pin_i)));
endmodule

// File: rtl/pin_irq_combine.sv
module pin_irq_combine #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] status_i,
    input  logic [NUM_PINS-1:0] en_i,
    output logic                irq_o
);
    logic [NUM_PINS-1:0] live;
    assign live = status_i & en_i;

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |live;
    end

    // R10: request asserted one cycle after an enabled pending bit
    p_irq_raise_r10: assert property (@(posedge clk) disable iff (rst)
        (live != '0) |=> irq_o);
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (live == '0) |=> !irq_o);
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic [3*NUM_PINS-1:0] trig_type,
    input  logic [NUM_PINS-1:0]   irq_en,
    input  logic [NUM_PINS-1:0]   irq_clr,
    output logic [NUM_PINS-1:0]   status,
    output logic                  irq
);
    trig_e               mode [NUM_PINS];
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] fall;

    pin_trig_decode #(.NUM_PINS(NUM_PINS)) u_decode (
        .type_i (trig_type),
        .mode_o (mode)
    );

    pin_edge_detect #(.NUM_PINS(NUM_PINS)) u_edges (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_in),
        .rise_o (rise),
        .fall_o (fall)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_cell
        pin_status_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .mode_i   (mode[g]),
            .pin_i    (pin_in[g]),
            .rise_i   (rise[g]),
            .fall_i   (fall[g]),
            .clr_i    (irq_clr[g]),
            .status_o (status[g])
        );
    end

    pin_irq_combine #(.NUM_PINS(NUM_PINS)) u_combine (
        .clk      (clk),
        .rst      (rst),
        .status_i (status),
        .en_i     (irq_en),
        .irq_o    (irq)
    );

    // R1: reset leaves status and request clear
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (status == '0 && !irq));
endmodule

// File: tb/test_pin_irq_detect.sv
module test_pin_irq_detect;
    localparam int N          = 8;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   pin_in = '0;
    logic [3*N-1:0] trig_type = '0;
    logic [N-1:0]   irq_en = '0;
    logic [N-1:0]   irq_clr = '0;
    logic [N-1:0]   status;
    logic           irq;

    pin_irq_detect #(.NUM_PINS(N)) i_pin_irq_detect (
        .clk(clk), .rst(rst), .pin_in(pin_in), .trig_type(trig_type),
        .irq_en(irq_en), .irq_clr(irq_clr), .status(status), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [N-1:0] st;
        logic         rq;
        string        tag;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // Reference model state
    logic [N-1:0]   m_st = '0;
    logic [N-1:0]   m_prev = '0;
    bit             m_primed = 0;
    logic [3*N-1:0] cfg_type = '0;
    logic [N-1:0]   cfg_en = '0;

    task automatic set_pin_mode(input int p, input bit pol, input bit edg, input bit dual);
        cfg_type[p]       = pol;
        cfg_type[N + p]   = edg;
        cfg_type[2*N + p] = dual;
    endtask

    task automatic apply(input logic [N-1:0] p, input logic [N-1:0] c, input string tag);
        logic [N-1:0] ns;
        item_t it;
        @(negedge clk);
        rst = 1'b0; pin_in = p; irq_clr = c; trig_type = cfg_type; irq_en = cfg_en;
        for (int i = 0; i < N; i++) begin
            bit pol, edg, dual, r, f, hit;
            pol  = cfg_type[i];
            edg  = cfg_type[N + i];
            dual = cfg_type[2*N + i];
            r = m_primed && !m_prev[i] && p[i];
            f = m_primed && m_prev[i] && !p[i];
            if (edg) begin
                if (dual)     hit = r || f;
                else if (pol) hit = r;
                else          hit = f;
                ns[i] = hit || (m_st[i] && !c[i]);
            end else begin
                ns[i] = (p[i] == pol);
            end
        end
        it.rq  = |(m_st & cfg_en);
        it.st  = ns;
        it.tag = tag;
        q.push_back(it);
        m_st = ns; m_prev = p; m_primed = 1;
    endtask

    // Monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_checks++;
                if (status !== it.st || irq !== it.rq) begin
                    n_fails++;
                    $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                             it.tag, status, irq, it.st, it.rq);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // Reset phase, pins toggled while held (R1)
        rst = 1'b1;
        repeat (2) @(negedge clk);
        pin_in = 8'h5A;
        @(negedge clk);
        n_checks++;
        if (status !== '0 || irq !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: status=%h irq=%b expected status=00 irq=0", status, irq);
        end
        pin_in = '0;

        // Mixed trigger kinds per pin (R12)
        set_pin_mode(0, 1, 1, 0); // rising
        set_pin_mode(1, 0, 1, 0); // falling
        set_pin_mode(2, 0, 1, 1); // both
        set_pin_mode(3, 1, 0, 0); // level high
        set_pin_mode(4, 0, 0, 0); // level low
        set_pin_mode(5, 1, 0, 1); // level high, dual ignored
        set_pin_mode(6, 1, 1, 1); // both with pol set
        set_pin_mode(7, 1, 1, 0); // rising
        cfg_en = 8'hFF;

        apply(8'hFF, 8'h00, "R11");   // first edge out of reset: no edges
        apply(8'hFF, 8'h00, "R5");
        apply(8'h00, 8'h00, "R3");    // falls on all pins
        apply(8'h00, 8'hFF, "R7");    // clear all edge status
        apply(8'h00, 8'h00, "R6");
        apply(8'h04, 8'h00, "R4");    // pin2 rises only
        apply(8'h00, 8'h00, "R4");    // pin2 falls
        apply(8'h00, 8'h04, "R7");
        apply(8'h01, 8'h00, "R2");    // pin0 rises
        apply(8'h00, 8'h00, "R2");    // pin0 falls: no new set
        apply(8'h00, 8'h00, "R7");    // sticky, clear 0 no effect
        apply(8'h01, 8'h01, "R8");    // pin0 rise with clear
        apply(8'h00, 8'h01, "R7");
        apply(8'h02, 8'h00, "R3");    // pin1 rises: no set
        apply(8'h00, 8'h02, "R8");    // pin1 falls with clear
        apply(8'h08, 8'h08, "R9");    // level high pin3 cleared
        apply(8'h08, 8'h08, "R9");
        apply(8'h20, 8'h30, "R9");    // pin5 high, pin4 low-level active
        cfg_en = 8'h00;
        apply(8'h88, 8'h00, "R10");   // status sets but no request
        apply(8'h88, 8'h00, "R10");
        cfg_en = 8'h08;
        apply(8'h88, 8'h00, "R10");
        apply(8'h00, 8'hFF, "R10");
        set_pin_mode(0, 0, 0, 0);     // pin0 becomes level low
        apply(8'h00, 8'h00, "R6");
        apply(8'h01, 8'h00, "R6");

        // Randomised phase
        lfsr = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (k % 37 == 0) cfg_type = {lfsr[7:0], lfsr[15:8], lfsr[11:4]};
            if (k % 23 == 0) cfg_en = lfsr[12:5];
            apply(lfsr[7:0], lfsr[15:8] & lfsr[11:4], "R12");
        end

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule